// File: doc/BRIEF.md
# Shift and Rotate Unit with Nibble Extension Buffer

This block performs one 16-bit shift or rotate per start strobe and keeps a 4-bit extension buffer beside the data path. Bits that leave the operand during a shift are caught in the buffer. The next shift or rotate takes the buffer contents back in, so a long value can be processed one word at a time. The unit offers logical and arithmetic right shifts, a logical left shift, and right and left rotates. Each moves the data by one to four places.

The operation class comes from a 2-bit kind input. Direction and distance come from a 3-bit field. Result, sign flag, zero flag and buffer are registered and appear one clock after the strobe, together with a one-cycle valid pulse. A separate save strobe copies the buffer into a shadow register so that an interrupt handler can keep it. The asynchronous reset is released through a synchronizer.

Top module: `shift_buffer_unit`

## Requirements
- R1: While reset is asserted, result, negative flag, zero flag, buffer, saved buffer and valid are all zero.
- R2: Field bit 2 selects the direction (1 = right, 0 = left). The distance is field bits 1:0 plus one, so right codes 4..7 and left codes 0..3 both give 1..4 places.
- R3: Kind 2'b00 with a right direction forms the 20-bit word {operand, buffer}, shifts it right and fills with zeros. The result is the upper 16 bits and the new buffer is the low nibble.
- R4: Kind 2'b01 with a right direction does the same as R3, but fills from the operand's bit 15 (sign fill).
- R5: Kind 2'b00 or 2'b01 with a left direction forms {buffer, operand}, shifts it left and fills with zeros. The result is the low 16 bits and the new buffer is the next four bits above them.
- R6: Kind 2'b10 or 2'b11 with a right direction rotates the 20-bit word {operand, buffer} right. The result is the upper 16 bits and the new buffer is the low nibble.
- R7: Kind 2'b10 or 2'b11 with a left direction rotates the 20-bit word {buffer, operand} left. The result is the low 16 bits and the new buffer is the top nibble.
- R8: Every completed operation sets the negative flag to result bit 15 and the zero flag to 1 exactly when the result is zero.
- R9: Without a start strobe, result, flags and buffer keep their values, whatever the other inputs do.
- R10: A save strobe copies the buffer into the saved-buffer output on the next edge, taking the value the buffer held before any shift in the same cycle. Without a save strobe the saved buffer holds its value.
- R11: Valid is high for exactly the one cycle after each start strobe, and the new result, flags and buffer are visible in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Perform one operation this cycle |
| kind_i | input | 2 | Operation class: 00 logical, 01 arithmetic, 1x rotate |
| field_i | input | 3 | Direction (bit 2) and distance minus one (bits 1:0) |
| operand_i | input | 16 | Data word to shift |
| irq_save_i | input | 1 | Copy the buffer into the saved-buffer register |
| result_o | output | 16 | Registered result |
| neg_o | output | 1 | Negative flag |
| zero_o | output | 1 | Zero flag |
| sb_o | output | 4 | Extension buffer |
| saved_sb_o | output | 4 | Saved copy of the buffer |
| valid_o | output | 1 | One-cycle pulse after each start |

## Verification
The properties are checked against the synchronized internal reset. They therefore assume that no start strobe is issued while that reset is still held after rst_ni rises. The stimulus keeps several idle cycles after each release to meet this. The ones-count rotate property and the sign property assume that operand, kind and field are stable at the clock edge where start is high. The bench changes inputs only on the falling edge, and it also issues save and start strobes together in the same cycle to cover the ordering in R10.

// File: rtl/sbu_pkg.sv
package sbu_pkg;
  typedef enum logic [1:0] {
    SBU_LOGIC   = 2'b00,
    SBU_ARITH   = 2'b01,
    SBU_ROT     = 2'b10,
    SBU_ROT_ALT = 2'b11
  } sbu_kind_e;
endpackage

// File: rtl/sbu_rst_sync.sv
module sbu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= 1'b1;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/sbu_amount_decode.sv
module sbu_amount_decode #(
  parameter int FIELD_W = 3,
  parameter int AMT_W   = 3
) (
  input  logic [FIELD_W-1:0] field_i,
  output logic               right_o,
  output logic [AMT_W-1:0]   amt_o
);
  // Top bit picks direction; remaining bits hold distance minus one.
  assign right_o = field_i[FIELD_W-1];
  assign amt_o   = AMT_W'(field_i[FIELD_W-2:0]) + AMT_W'(1);
endmodule

// File: rtl/sbu_shift_core.sv
module sbu_shift_core
  import sbu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BUF_W  = 4,
  parameter int AMT_W  = 3
) (
  input  logic [DATA_W-1:0] op_i,
  input  logic [BUF_W-1:0]  sb_i,
  input  sbu_kind_e         kind_i,
  input  logic              right_i,
  input  logic [AMT_W-1:0]  amt_i,
  output logic [DATA_W-1:0] res_o,
  output logic [BUF_W-1:0]  sb_o
);
  localparam int WIDE_W = DATA_W + 3*BUF_W;

  logic              sign_fill;
  logic [WIDE_W-1:0] shr_src, shl_src, rot_src;
  logic [WIDE_W-1:0] shr_out, shl_out, ror_out, rol_out;

  always_comb begin
    sign_fill = (kind_i == SBU_ARITH) & op_i[DATA_W-1];
    shr_src   = {{(2*BUF_W){sign_fill}}, op_i, sb_i};
    shl_src   = WIDE_W'({sb_i, op_i});
    rot_src   = WIDE_W'({sb_i, op_i, sb_i});
    shr_out   = shr_src >> amt_i;
    shl_out   = shl_src << amt_i;
    ror_out   = rot_src >> amt_i;
    rol_out   = rot_src << amt_i;

    if (kind_i inside {SBU_ROT, SBU_ROT_ALT}) begin
      if (right_i) begin
        res_o = DATA_W'(ror_out >> BUF_W);
        sb_o  = BUF_W'(ror_out);
      end else begin
        res_o = DATA_W'(rol_out >> BUF_W);
        sb_o  = BUF_W'(rol_out >> (DATA_W + BUF_W));
      end
    end else if (right_i) begin
      res_o = DATA_W'(shr_out >> BUF_W);
      sb_o  = BUF_W'(shr_out);
    end else begin
      res_o = DATA_W'(shl_out);
      sb_o  = BUF_W'(shl_out >> DATA_W);
    end
  end
endmodule

// File: rtl/shift_buffer_unit.sv
module shift_buffer_unit
  import sbu_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int BUF_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [1:0]             kind_i,
  input  logic [$clog2(BUF_W):0] field_i,
  input  logic [DATA_W-1:0]      operand_i,
  input  logic                   irq_save_i,
  output logic [DATA_W-1:0]      result_o,
  output logic                   neg_o,
  output logic                   zero_o,
  output logic [BUF_W-1:0]       sb_o,
  output logic [BUF_W-1:0]       saved_sb_o,
  output logic                   valid_o
);
  localparam int LOG_BUF = $clog2(BUF_W);
  localparam int FIELD_W = LOG_BUF + 1;
  localparam int AMT_W   = LOG_BUF + 1;

  logic              rst_sync_n;
  logic              dir_right;
  logic [AMT_W-1:0]  amt;
  logic [DATA_W-1:0] core_res;
  logic [BUF_W-1:0]  core_sb;

  logic [DATA_W-1:0] res_q, res_d;
  logic              neg_q, neg_d, zero_q, zero_d, valid_q, valid_d;
  logic [BUF_W-1:0]  sb_q, sb_d, saved_q, saved_d;
  logic              upd_en, save_en;

  sbu_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk    (clk),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  sbu_amount_decode #(.FIELD_W(FIELD_W), .AMT_W(AMT_W)) i_decode (
    .field_i (field_i),
    .right_o (dir_right),
    .amt_o   (amt)
  );

  sbu_shift_core #(.DATA_W(DATA_W), .BUF_W(BUF_W), .AMT_W(AMT_W)) i_core (
    .op_i    (operand_i),
    .sb_i    (sb_q),
    .kind_i  (sbu_kind_e'(kind_i)),
    .right_i (dir_right),
    .amt_i   (amt),
    .res_o   (core_res),
    .sb_o    (core_sb)
  );

  // Next-state
  always_comb begin
    upd_en  = start_i;
    save_en = irq_save_i;
    res_d   = core_res;
    sb_d    = core_sb;
    neg_d   = core_res[DATA_W-1];
    zero_d  = (core_res == '0);
    saved_d = sb_q;
    valid_d = start_i;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_q   <= '0;
      neg_q   <= 1'b0;
      zero_q  <= 1'b0;
      sb_q    <= '0;
      saved_q <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
      if (upd_en) begin
        res_q  <= res_d;
        neg_q  <= neg_d;
        zero_q <= zero_d;
        sb_q   <= sb_d;
      end
      if (save_en) begin
        saved_q <= saved_d;
      end
    end
  end

  assign result_o   = res_q;
  assign neg_o      = neg_q;
  assign zero_o     = zero_q;
  assign sb_o       = sb_q;
  assign saved_sb_o = saved_q;
  assign valid_o    = valid_q;
endmodule

// File: rtl/sbu_checker.sv
module sbu_checker #(
  parameter int DATA_W = 16,
  parameter int BUF_W  = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start_i,
  input logic [1:0]             kind_i,
  input logic [$clog2(BUF_W):0] field_i,
  input logic [DATA_W-1:0]      operand_i,
  input logic                   irq_save_i,
  input logic [DATA_W-1:0]      result_o,
  input logic                   neg_o,
  input logic                   zero_o,
  input logic [BUF_W-1:0]       sb_o,
  input logic [BUF_W-1:0]       saved_sb_o,
  input logic                   valid_o
);
  localparam int FMSB = $clog2(BUF_W);

  p_asr_keeps_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && kind_i == 2'b01 && field_i[FMSB]) |=> result_o[DATA_W-1] == $past(operand_i[DATA_W-1]));

  p_shl_zero_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !kind_i[1] && !field_i[FMSB]) |=> result_o[0] == 1'b0);

  p_rotate_keeps_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && kind_i[1]) |=> $countones({result_o, sb_o}) == $countones({$past(operand_i), $past(sb_o)}));

  p_neg_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> neg_o == result_o[DATA_W-1]);

  p_zero_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> zero_o == (result_o == '0));

  p_hold_without_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> ($stable(result_o) && $stable(sb_o) && $stable(neg_o) && $stable(zero_o)));

  p_save_takes_old_sb_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_save_i |=> saved_sb_o == $past(sb_o));

  p_saved_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_save_i |=> $stable(saved_sb_o));

  p_valid_after_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> valid_o);

  p_no_valid_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !valid_o);
endmodule

bind shift_buffer_unit sbu_checker #(.DATA_W(DATA_W), .BUF_W(BUF_W)) i_sbu_checker (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .start_i    (start_i),
  .kind_i     (kind_i),
  .field_i    (field_i),
  .operand_i  (operand_i),
  .irq_save_i (irq_save_i),
  .result_o   (result_o),
  .neg_o      (neg_o),
  .zero_o     (zero_o),
  .sb_o       (sb_o),
  .saved_sb_o (saved_sb_o),
  .valid_o    (valid_o)
);

// File: tb/test_shift_buffer_unit.sv
module test_shift_buffer_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        start_i;
  logic [1:0]  kind_i;
  logic [2:0]  field_i;
  logic [15:0] operand_i;
  logic        irq_save_i;
  logic [15:0] result_o;
  logic        neg_o, zero_o, valid_o;
  logic [3:0]  sb_o, saved_sb_o;

  int tests  = 0;
  int failed = 0;
  bit done   = 0;

  // reference state
  int m_res, m_sb, m_saved;
  bit m_n, m_z, m_valid;

  always #(CLK_PERIOD/2) clk = ~clk;

  shift_buffer_unit i_shift_buffer_unit (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .kind_i     (kind_i),
    .field_i    (field_i),
    .operand_i  (operand_i),
    .irq_save_i (irq_save_i),
    .result_o   (result_o),
    .neg_o      (neg_o),
    .zero_o     (zero_o),
    .sb_o       (sb_o),
    .saved_sb_o (saved_sb_o),
    .valid_o    (valid_o)
  );

  task automatic model_op(input int kd, input int fd, input int op);
    int amt, v;
    bit right;
    amt   = (fd % 4) + 1;
    right = (fd >= 4);
    if (kd >= 2) begin
      v = (m_sb << 20) | (op << 4) | m_sb;
      if (right) begin
        v     = v >> amt;
        m_res = (v >> 4) & 16'hFFFF;
        m_sb  = v & 15;
      end else begin
        v     = v << amt;
        m_res = (v >> 4) & 16'hFFFF;
        m_sb  = (v >> 20) & 15;
      end
    end else if (right) begin
      v = (op << 4) | m_sb;
      if (kd == 1 && (op & 16'h8000) != 0) v = v | 24'hF00000;
      v     = v >> amt;
      m_res = (v >> 4) & 16'hFFFF;
      m_sb  = v & 15;
    end else begin
      v     = ((m_sb << 16) | op) << amt;
      m_res = v & 16'hFFFF;
      m_sb  = (v >> 16) & 15;
    end
    m_n = (m_res >= 32768);
    m_z = (m_res == 0);
  endtask

  task automatic step(input bit st, input int kd, input int fd, input int op,
                      input bit irq, input string tag);
    start_i    = st;
    kind_i     = 2'(kd);
    field_i    = 3'(fd);
    operand_i  = 16'(op);
    irq_save_i = irq;
    if (!rst_ni) begin
      m_res = 0; m_sb = 0; m_saved = 0; m_n = 0; m_z = 0; m_valid = 0;
    end else begin
      if (irq) m_saved = m_sb;
      if (st) model_op(kd, fd, op);
      m_valid = st;
    end
    @(posedge clk);
    @(negedge clk);
    tests++;
    if (result_o !== 16'(m_res) || neg_o !== m_n || zero_o !== m_z ||
        sb_o !== 4'(m_sb) || saved_sb_o !== 4'(m_saved) || valid_o !== m_valid) begin
      failed++;
      $display("FAIL %s: actual res=%h n=%b z=%b sb=%h saved=%h valid=%b expected res=%h n=%b z=%b sb=%h saved=%h valid=%b",
               tag, result_o, neg_o, zero_o, sb_o, saved_sb_o, valid_o,
               16'(m_res), m_n, m_z, 4'(m_sb), 4'(m_saved), m_valid);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      tests++;
      failed++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0;
    start_i = 0; kind_i = 0; field_i = 0; operand_i = 0; irq_save_i = 0;
    // R1: reset state, even with strobes present
    step(1, 0, 4, 16'hFFFF, 1, "R1");
    step(1, 2, 0, 16'h1234, 0, "R1");
    @(negedge clk);
    rst_ni = 1'b1;
    // R9: idle through reset synchronizer release
    for (int i = 0; i < 4; i++) step(0, 0, 0, 16'hA5A5, 0, "R9");

    // R3: logical right, distances 1 and 4 (R2)
    step(1, 0, 4, 16'h1235, 0, "R3");
    step(1, 0, 7, 16'hF00F, 0, "R2");
    step(1, 0, 5, 16'h8001, 0, "R3");
    // R4: arithmetic right negative and positive
    step(1, 1, 7, 16'h8000, 0, "R4");
    step(1, 1, 6, 16'h4321, 0, "R4");
    step(1, 1, 4, 16'hFFFE, 0, "R4");
    // R5: left shift, logical and arithmetic kind
    step(1, 0, 0, 16'h8421, 0, "R5");
    step(1, 0, 3, 16'hABCD, 0, "R5");
    step(1, 1, 2, 16'hF123, 0, "R5");
    // R6: right rotate, both rotate codes
    step(1, 2, 4, 16'h0001, 0, "R6");
    step(1, 3, 7, 16'h1234, 0, "R6");
    // R7: left rotate
    step(1, 2, 0, 16'h8000, 0, "R7");
    step(1, 3, 3, 16'hC00F, 0, "R7");
    // R8: zero result and negative result
    step(1, 0, 7, 16'h0001, 0, "R8");
    step(1, 1, 4, 16'h8000, 0, "R8");
    // R9: inputs change without start
    step(0, 2, 3, 16'h5555, 0, "R9");
    step(0, 1, 6, 16'hFFFF, 0, "R9");
    // R10: save alone, then save together with a shift
    step(0, 0, 0, 16'h0000, 1, "R10");
    step(1, 0, 3, 16'hFFFF, 1, "R10");
    step(0, 0, 0, 16'h0000, 0, "R10");
    // R11: back-to-back starts then idle
    step(1, 2, 1, 16'h0F0F, 0, "R11");
    step(1, 2, 5, 16'hF0F0, 0, "R11");
    step(0, 0, 0, 16'h0000, 0, "R11");
    // R11: mixed sequence, compared every cycle
    for (int i = 0; i < 400; i++)
      step(bit'($urandom_range(0, 3) != 0), int'($urandom_range(0, 3)),
           int'($urandom_range(0, 7)), int'($urandom_range(0, 65535)),
           bit'($urandom_range(0, 4) == 0), "R11");
    // R1: reset in mid-operation
    rst_ni = 1'b0;
    step(1, 0, 4, 16'h1234, 1, "R1");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule